// File: doc/BRIEF.md
# Arbiter PUF Delay-Model Evaluator

This block is a synthesizable stand-in for an n-stage arbiter physically unclonable function. It uses the additive linear delay model instead of an analog race. Each instance holds n+1 signed stage weights that play the role of manufacturing variation. They are filled in right after reset from a per-instance seed by a 32-bit maximal-length LFSR. A caller presents an n-bit challenge with a one-cycle `start` strobe. The block reports a one-bit response with a one-cycle `done` strobe.

The response is the sign of a dot product between the weights and a feature vector derived from the challenge. Each feature is +1 or -1 according to the parity of the challenge bits from its own position up to the top bit. The top bit therefore touches every term and dominates the result. A final feature is fixed at +1 and carries a bias weight. The sum is built one term per clock, walking from the top challenge bit downward so that a single running parity bit gives each feature.

The controller is a state machine with five states:
- `ST_LOAD`: fills the weights after reset, then moves to `ST_IDLE` on its last write.
- `ST_IDLE`: waits for `start`, and on `start` moves to `ST_BIAS`.
- `ST_BIAS`: adds the bias term, then moves to `ST_STAGE`.
- `ST_STAGE`: adds one signed stage term per cycle and moves to `ST_DECIDE` after stage 0.
- `ST_DECIDE`: registers the sign, then returns to `ST_IDLE`.

Top module: `apuf_eval`

## Requirements
- R1: While `rst_n` is low, `busy`=1, `done`=0 and `resp`=0. After release, `busy` stays 1 for exactly NSTG+1 rising edges (weight load) and is 0 after the (NSTG+1)-th edge.
- R2: The LFSR starts from SEED, or from 1 if SEED is zero. Each step shifts it left and inserts s[31]^s[21]^s[1]^s[0] at bit 0. Weight k (k = 0..NSTG) is the low WW bits, read as two's complement, of the state after k+1 steps.
- R3: The feature for stage i (0 ≤ i < NSTG) is +1 when challenge bits i..NSTG-1 have even parity and -1 when that parity is odd. Bit NSTG-1 is the bit nearest the arbiter.
- R4: The bias weight (index NSTG) is always added with feature +1, whatever the challenge.
- R5: `resp` is 1 when the sum of weight × feature over all NSTG+1 terms is strictly positive. It is 0 when the sum is negative or exactly zero.
- R6: A `start` accepted at a rising edge makes `busy` 1 from that edge on. `done` is 1 for exactly one cycle, after the (NSTG+2)-th rising edge following acceptance, and `busy` is 0 again after that same edge.
- R7: `start` is ignored when `busy` is 1, both during the weight load and during an evaluation. An ignored `start` neither changes the result nor adds a second evaluation.
- R8: `resp` changes only on the edge that raises `done`, and holds its value between evaluations.
- R9: The accumulator never overflows, even for the challenges that give the largest positive or negative reachable sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to evaluate `challenge` |
| challenge | input | NSTG | Challenge bits, sampled with an accepted `start` |
| busy | output | 1 | High during the weight load and during an evaluation |
| done | output | 1 | One-cycle strobe marking a fresh `resp` |
| resp | output | 1 | Response bit: sign of the weighted feature sum |

## Verification
The hardest situation to reach from the ports is a sum that sits right next to zero. With random challenges the magnitude is nearly always far from the boundary. The bench therefore scans thousands of challenges through its own model and applies the ones with the smallest positive sum and the smallest-magnitude negative sum. It also builds, from the model's weights, the challenges whose features line up with every weight sign, or oppose every weight sign, to drive the accumulator to the ends of its reachable range.

// File: rtl/apuf_pkg.sv
`timescale 1ns/1ps
package apuf_pkg;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_IDLE,
        ST_BIAS,
        ST_STAGE,
        ST_DECIDE
    } eval_state_t;

    // maximal-length 32-bit Fibonacci step (x^32 + x^22 + x^2 + x + 1)
    function automatic logic [31:0] lfsr32_next(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

endpackage

// File: rtl/apuf_weight_bank.sv
`timescale 1ns/1ps
module apuf_weight_bank #(
    parameter int          NW   = 65,
    parameter int          WW   = 16,
    parameter logic [31:0] SEED = 32'h1,
    parameter int          IW   = $clog2(NW)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [IW-1:0]        rd_idx,
    output logic signed [WW-1:0] rd_data,
    output logic                 load_last
);
    localparam logic [31:0] SEED_NZ = (SEED == 32'h0) ? 32'h1 : SEED;

    logic [31:0]          lfsr_q;
    logic [31:0]          lfsr_d;
    logic [IW-1:0]        widx_q;
    logic signed [WW-1:0] mem_q [NW];

    assign lfsr_d    = apuf_pkg::lfsr32_next(lfsr_q);
    assign load_last = (widx_q == IW'(NW - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED_NZ;
            widx_q <= '0;
        end else if (load_en) begin
            lfsr_q <= lfsr_d;
            if (!load_last) widx_q <= widx_q + 1'b1;
        end
    end

    generate
        for (genvar k = 0; k < NW; k++) begin : g_wreg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem_q[k] <= '0;
                else if (load_en && (widx_q == IW'(k)))
                    mem_q[k] <= lfsr_d[WW-1:0];
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) < NW) rd_data = mem_q[rd_idx];
    end

    // R2: write pointer never runs past the last weight
    a_r2_widx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        widx_q <= IW'(NW - 1));
    // R2: generator never locks up in the all-zero state
    a_r2_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 32'h0);

endmodule

// File: rtl/apuf_suffix_parity.sv
`timescale 1ns/1ps
module apuf_suffix_parity #(
    parameter int NSTG = 64,
    parameter int IW   = $clog2(NSTG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [NSTG-1:0] chal_in,
    input  logic            step,
    input  logic [IW-1:0]   bit_idx,
    output logic            neg
);
    localparam int SW = (NSTG > 1) ? $clog2(NSTG) : 1;

    logic [NSTG-1:0] chal_q;
    logic            par_q;
    logic            sel_bit;

    always_comb begin
        sel_bit = 1'b0;
        if (int'(bit_idx) < NSTG) sel_bit = chal_q[bit_idx[SW-1:0]];
    end

    // feature is -1 when the suffix parity including this bit is odd
    assign neg = par_q ^ sel_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chal_q <= '0;
            par_q  <= 1'b0;
        end else if (capture) begin
            chal_q <= chal_in;
            par_q  <= 1'b0;
        end else if (step) begin
            par_q  <= neg;
        end
    end

    // R7: the held challenge only changes on a capture
    a_r7_chal_held: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(chal_q));

endmodule

// File: rtl/apuf_accum.sv
`timescale 1ns/1ps
module apuf_accum #(
    parameter int WW = 16,
    parameter int AW = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 add_en,
    input  logic                 neg,
    input  logic signed [WW-1:0] term,
    output logic signed [AW-1:0] acc_q,
    output logic                 positive
);
    logic signed [AW-1:0] term_x;
    logic signed [AW-1:0] addend;

    assign term_x   = {{(AW-WW){term[WW-1]}}, term};
    assign addend   = neg ? -term_x : term_x;
    assign positive = !acc_q[AW-1] && (acc_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_q <= '0;
        else if (clr)    acc_q <= '0;
        else if (add_en) acc_q <= acc_q + addend;
    end

    // R9: adding a same-signed term never flips the sign (no wraparound)
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !clr && (acc_q[AW-1] == addend[AW-1]) && (acc_q != '0))
        |=> (acc_q[AW-1] == $past(acc_q[AW-1])));

endmodule

// File: rtl/apuf_eval.sv
`timescale 1ns/1ps
module apuf_eval #(
    parameter int          NSTG = 64,
    parameter int          WW   = 16,
    parameter logic [31:0] SEED = 32'h1357_9BDF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NSTG-1:0] challenge,
    output logic            busy,
    output logic            done,
    output logic            resp
);
    import apuf_pkg::*;

    localparam int NW = NSTG + 1;
    localparam int IW = $clog2(NW);
    localparam int AW = WW + $clog2(NSTG + 2);
    localparam int LW = IW + 1;

    eval_state_t          state_q, state_d;
    logic [IW-1:0]        cnt_q;
    logic [LW-1:0]        lat_q;
    logic                 done_q, resp_q;

    logic                 load_en, load_last;
    logic                 capture, add_en, step;
    logic                 feat_neg, term_neg;
    logic signed [WW-1:0] weight;
    logic signed [AW-1:0] acc;
    logic                 positive;

    // ---------------- next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:   if (load_last) state_d = ST_IDLE;
            ST_IDLE:   if (start)     state_d = ST_BIAS;
            ST_BIAS:                  state_d = ST_STAGE;
            ST_STAGE:  if (cnt_q == '0) state_d = ST_DECIDE;
            ST_DECIDE:                state_d = ST_IDLE;
            default:                  state_d = ST_LOAD;
        endcase
    end

    // ---------------- state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    // ---------------- datapath controls
    assign load_en  = (state_q == ST_LOAD);
    assign capture  = (state_q == ST_IDLE) && start;
    assign add_en   = (state_q == ST_BIAS) || (state_q == ST_STAGE);
    assign step     = (state_q == ST_STAGE);
    assign term_neg = step && feat_neg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lat_q <= '0;
        end else begin
            if (capture)                              cnt_q <= IW'(NSTG);
            else if (state_q == ST_BIAS)              cnt_q <= IW'(NSTG - 1);
            else if (state_q == ST_STAGE && cnt_q != '0) cnt_q <= cnt_q - 1'b1;

            if (capture)     lat_q <= '0;
            else if (busy && state_q != ST_LOAD) lat_q <= lat_q + 1'b1;
        end
    end

    // ---------------- outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            resp_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_DECIDE);
            if (state_q == ST_DECIDE) resp_q <= positive;
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;
    assign resp = resp_q;

    // ---------------- submodules
    apuf_weight_bank #(.NW(NW), .WW(WW), .SEED(SEED), .IW(IW)) u_bank (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .rd_idx(cnt_q),
        .rd_data(weight), .load_last(load_last)
    );

    apuf_suffix_parity #(.NSTG(NSTG), .IW(IW)) u_feat (
        .clk(clk), .rst_n(rst_n), .capture(capture), .chal_in(challenge),
        .step(step), .bit_idx(cnt_q), .neg(feat_neg)
    );

    apuf_accum #(.WW(WW), .AW(AW)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(capture), .add_en(add_en),
        .neg(term_neg), .term(weight), .acc_q(acc), .positive(positive)
    );

    // ---------------- assertions
    // R6: done is a single-cycle strobe
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R6: done arrives NSTG+2 edges after acceptance
    a_r6_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (lat_q == LW'(NSTG + 2)));
    // R7: a start seen while busy never launches an evaluation
    a_r7_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> (state_q != ST_BIAS));
    // R8: response only moves together with done
    a_r8_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> $stable(resp_q));
    // R5: an exactly-zero sum resolves to 0
    a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && acc == '0) |=> !resp_q);
    // R4: the bias term is read from the last weight slot
    a_r4_bias_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BIAS) |-> (cnt_q == IW'(NSTG)));

endmodule

// File: tb/sim_apuf_eval.sv
`timescale 1ns/1ps
module sim_apuf_eval;
    localparam int          N    = 64;
    localparam logic [31:0] SEED = 32'hA5C3_1E77;

    logic         clk, rst_n, start;
    logic [N-1:0] challenge;
    logic         busy, done, resp;

    int checks = 0;
    int errors = 0;
    int w [N+1];

    apuf_eval #(.NSTG(N), .WW(16), .SEED(SEED)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .challenge(challenge),
        .busy(busy), .done(done), .resp(resp)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] step32(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic int model_sum(input logic [N-1:0] ch);
        int  acc = w[N];
        bit  p   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            p = p ^ ch[i];
            acc = p ? acc - w[i] : acc + w[i];
        end
        return acc;
    endfunction

    // build a challenge from desired per-stage feature signs (1 = feature -1)
    function automatic logic [N-1:0] from_features(input logic [N-1:0] fneg);
        logic [N-1:0] ch;
        for (int i = 0; i < N; i++)
            ch[i] = fneg[i] ^ ((i == N - 1) ? 1'b0 : fneg[i+1]);
        return ch;
    endfunction

    task automatic run_eval(input logic [N-1:0] ch, input string tag, input bit poke);
        int sum;
        bit exp_r, early;
        logic held;
        sum   = model_sum(ch);
        exp_r = (sum > 0);
        early = 1'b0;
        @(negedge clk);
        start = 1'b1; challenge = ch;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R6", {tag, " busy after accept"}, busy, 1);
        held = resp;
        for (int k = 1; k <= N + 1; k++) begin
            @(posedge clk); @(negedge clk);
            if (done) early = 1'b1;
            if (resp !== held) early = 1'b1;
            if (poke && k == 10) begin start = 1'b1; challenge = ~ch; end
            else start = 1'b0;
        end
        chk(!early, "R6", {tag, " no early done or resp change"}, early, 0);
        @(posedge clk); @(negedge clk);
        chk(done == 1'b1, "R6", {tag, " done at NSTG+2"}, done, 1);
        chk(resp == exp_r, poke ? "R7" : "R5", {tag, " response"}, resp, exp_r);
        @(posedge clk); @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R6", {tag, " done pulse ends, idle"},
            {done, busy}, 0);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0]  s;
        logic [N-1:0] ch, best_pos, best_neg, fneg;
        int           sp, sn, v;
        bit           seen;

        // bench-side weights (R2)
        s = SEED;
        for (int k = 0; k <= N; k++) begin
            s = step32(s);
            w[k] = int'($signed(s[15:0]));
        end

        rst_n = 1'b0; start = 1'b0; challenge = '0;
        repeat (3) @(negedge clk);
        chk(busy == 1 && done == 0 && resp == 0, "R1", "reset outputs",
            {busy, done, resp}, 3'b100);
        rst_n = 1'b1;

        seen = 1'b0;
        for (int k = 1; k <= N + 1; k++) begin
            @(posedge clk); @(negedge clk);
            if (done) seen = 1'b1;
            if (k == N) chk(busy == 1'b1, "R1", "busy during load", busy, 1);
            if (k == N + 1) chk(busy == 1'b0, "R1", "idle after load", busy, 0);
            start = (k == 10);
            challenge = '1;
        end
        chk(!seen, "R7", "start ignored during load", seen, 0);
        start = 1'b0;

        // directed patterns
        run_eval('0, "R4 all-zero challenge", 1'b0);
        run_eval('1, "R4 all-one challenge", 1'b0);
        ch = 64'h0123_4567_89AB_CDEF;
        run_eval(ch, "R3 pattern", 1'b0);
        run_eval(ch ^ (64'h1 << (N - 1)), "R3 top bit flipped", 1'b0);
        run_eval(ch ^ 64'h1, "R3 bit 0 flipped", 1'b0);

        // extremes of the reachable sum (R9)
        for (int i = 0; i < N; i++) fneg[i] = (w[i] < 0);
        run_eval(from_features(fneg), "R9 largest positive sum", 1'b0);
        run_eval(from_features(~fneg), "R9 largest negative sum", 1'b0);

        // sums nearest zero (R5)
        void'($urandom(32'd2024));
        sp = 32'h7FFF_FFFF; sn = -32'sh7FFF_FFFF;
        best_pos = '0; best_neg = '0;
        for (int t = 0; t < 6000; t++) begin
            ch = {$urandom, $urandom};
            v  = model_sum(ch);
            if (v > 0 && v < sp) begin sp = v; best_pos = ch; end
            if (v <= 0 && v > sn) begin sn = v; best_neg = ch; end
        end
        run_eval(best_pos, "R5 smallest positive sum", 1'b0);
        run_eval(best_neg, "R5 near-zero non-positive sum", 1'b0);

        // start during an evaluation (R7)
        run_eval({$urandom, $urandom}, "R7 start while busy", 1'b1);

        // response holds while idle (R8)
        begin
            logic held;
            bit   moved;
            held  = resp;
            moved = 1'b0;
            repeat (6) begin
                @(posedge clk); @(negedge clk);
                if (resp !== held) moved = 1'b1;
            end
            chk(!moved, "R8", "resp held while idle", moved, 0);
        end

        // constrained-random (R2, R3, R5)
        for (int t = 0; t < 150; t++)
            run_eval({$urandom, $urandom}, "R2 random challenge", (t % 17) == 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule